// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Serial Bus

This block is a write-only target on an I2C bus. It oversamples SCL and SDA with the system clock and finds START and STOP conditions. It shifts in bytes MSB first, compares the first byte of each transfer against a fixed 7-bit device address with the write bit, and acknowledges by pulling SDA low through an open-drain enable. Once the address has been acknowledged, every following byte is acknowledged until the next START or STOP.

No register pointer exists. Each data byte carries a variable-length prefix that names the register it writes. The block holds one volume setting, four speaker attenuators, an input switch and two tone nibbles. It presents the raw fields and also decoded values: attenuation in quarter-dB units, a mute flag per speaker, input gain in quarter-dB units, and signed tone gain in dB.

A system controller writes the registers over the bus. Downstream analog or digital audio logic takes the decoded outputs directly.

Top module: `audio_ctrl_i2c_slave`

## Requirements
- R1: START (SDA falls while SCL is high) begins address matching from the first bit at any time, including in the middle of a byte or of a transfer. STOP (SDA rises while SCL is high) returns the block to idle.
- R2: The address byte 0x88 (address 1000100 followed by write bit 0) is acknowledged by asserting `sdaOe` for the whole ninth clock. `sdaOe` changes only while SCL is low.
- R3: After a matched address, every data byte is acknowledged, for any number of bytes up to the STOP.
- R4: An address byte other than 0x88, including the read form 0x89, gets no acknowledge. All later bytes are then ignored and not acknowledged until the next START or STOP, and no register changes.
- R5: A data byte writes exactly one register, chosen by its prefix: `00` volume; `1xx` speaker, where bits 6:5 give 0 left front, 1 right front, 2 left rear, 3 right rear; `010` input switch; `0110` bass; `0111` treble.
- R6: Volume code bits 5:0 are stored in `volCode`. `volAttenQdb` = 40×bits[5:3] + 5×bits[2:0], so byte 0x24 gives 180 (45 dB).
- R7: Speaker code bits 4:0 are stored. The attenuation is 40×bits[4:3] + 5×bits[2:0] quarter-dB, so 0xB4 sets right front to 100 (25 dB). The speaker's mute flag is set exactly when its code is 11111.
- R8: Input switch byte 010 G1G0 S2S1S0 sets `inputSel` = S1S0, `loudnessOn` = not S2, `gainCode` = G and `inGainQdb` = 15×(3−G), so G = 00 gives 45 and G = 11 gives 0.
- R9: The tone nibble C3..C0 gives a gain of −14+2×C[2:0] dB when C3 = 0, and 2×(7−C[2:0]) dB when C3 = 1. Byte 0x62 sets bass to −10 dB.
- R10: A register changes only after the acknowledge clock of a complete data byte. A byte cut short by a START or a STOP changes nothing.
- R11: After reset, volume code = 111111, every speaker code = 11111 (muted), bass and treble = 0111 (0 dB), input 1 is selected, gain code = 11 (0 dB), loudness is off, and `sdaOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than the bus bit rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | Pull SDA low when 1 (open-drain drive) |
| volCode | output | 6 | Raw volume code |
| volAttenQdb | output | 9 | Volume attenuation in 0.25 dB units |
| spkCode | output | 4x5 | Raw speaker codes, index 0 LF, 1 RF, 2 LR, 3 RR |
| spkAttenQdb | output | 4x8 | Speaker attenuation in 0.25 dB units |
| spkMute | output | 4 | Per-speaker mute flag |
| inputSel | output | 2 | Selected stereo input, 0 = input 1 |
| loudnessOn | output | 1 | Loudness enabled |
| gainCode | output | 2 | Raw input gain code |
| inGainQdb | output | 6 | Input gain in 0.25 dB units |
| bassCode | output | 4 | Raw bass nibble |
| trebleCode | output | 4 | Raw treble nibble |
| bassGainDb | output | 5 | Signed bass gain in dB |
| trebleGainDb | output | 5 | Signed treble gain in dB |

## Verification
Assertions check four properties on every cycle. The acknowledge drive moves only while SCL is low. A skipped transfer never drives the line. Each completed byte changes at most one register. Every register holds its value between byte strobes. Only the bench's scenarios can show the decode arithmetic over every code, the effect of the prefix selection, and the mismatch, read-bit and abort cases. There the bench drives real bus waveforms and checks the acknowledge bit and the decoded outputs after each byte.

// File: rtl/audio_i2c_pkg.sv
package audio_i2c_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_SPK  = 4;
  localparam int VOL_QW   = 9;
  localparam int SPK_QW   = 8;
  localparam int GAIN_QW  = 6;
  localparam int TONE_W   = 5;

  typedef struct packed {
    logic              valid;
    logic [BYTE_W-1:0] data;
  } byteStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } busState_t;

  function automatic logic signed [TONE_W-1:0] toneDb(input logic [3:0] nib);
    int v;
    v = nib[3] ? 2 * (7 - int'(nib[2:0])) : -14 + 2 * int'(nib[2:0]);
    return TONE_W'(v);
  endfunction
endpackage

// File: rtl/i2c_wr_ctrl.sv
module i2c_wr_ctrl
  import audio_i2c_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR    = 7'h44
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  output byteStrobe_t strobe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg, holdByte;
  logic ackPhase;

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync  <= '1;
      sdaSync  <= '1;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      holdByte <= '0;
      ackPhase <= 1'b0;
      sdaOe    <= 1'b0;
      strobe   <= '0;
    end else begin
      sclSync      <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync      <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev      <= sclS;
      sdaPrev      <= sdaS;
      strobe.valid <= 1'b0;
      if (startDet || stopDet) begin
        state    <= startDet ? ST_ADDR : ST_IDLE;
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        sdaOe    <= 1'b0;
      end else if (state == ST_ADDR || state == ST_DATA) begin
        if (sclRise && !ackPhase) begin
          shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
          bitCnt   <= bitCnt + 1'b1;
        end else if (sclFall) begin
          if (ackPhase) begin
            ackPhase <= 1'b0;
            sdaOe    <= 1'b0;
            if (state == ST_DATA) strobe <= '{valid: 1'b1, data: holdByte};
            else                  state  <= ST_DATA;
          end else if (bitCnt == CNT_W'(BYTE_W)) begin
            bitCnt <= '0;
            if (state == ST_DATA) begin
              ackPhase <= 1'b1;
              sdaOe    <= 1'b1;
              holdByte <= shiftReg;
            end else if (shiftReg == ADDR_WR) begin
              ackPhase <= 1'b1;
              sdaOe    <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
      end
    end
  end

  assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((sdaOe != $past(sdaOe)) && !$past(startDet || stopDet)) |-> !sclS);

  assert_skip_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaOe);

  assert_start_rearm_R1: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == '0 && !ackPhase));

  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.valid |=> !strobe.valid);
endmodule

// File: rtl/audio_reg_bank.sv
module audio_reg_bank
  import audio_i2c_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  byteStrobe_t                        strobe,
  output logic [5:0]                         volCode,
  output logic [VOL_QW-1:0]                  volAttenQdb,
  output logic [NUM_SPK-1:0][4:0]            spkCode,
  output logic [NUM_SPK-1:0][SPK_QW-1:0]     spkAttenQdb,
  output logic [NUM_SPK-1:0]                 spkMute,
  output logic [1:0]                         inputSel,
  output logic                               loudnessOn,
  output logic [1:0]                         gainCode,
  output logic [GAIN_QW-1:0]                 inGainQdb,
  output logic [3:0]                         bassCode,
  output logic [3:0]                         trebleCode,
  output logic signed [TONE_W-1:0]           bassGainDb,
  output logic signed [TONE_W-1:0]           trebleGainDb
);
  logic [BYTE_W-1:0] d;
  logic hitVol, hitSw, hitBass, hitTreb;
  logic [4:0] swCode;

  assign d       = strobe.data;
  assign hitVol  = strobe.valid && d[7:6] == 2'b00;
  assign hitSw   = strobe.valid && d[7:5] == 3'b010;
  assign hitBass = strobe.valid && d[7:4] == 4'b0110;
  assign hitTreb = strobe.valid && d[7:4] == 4'b0111;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      volCode    <= 6'h3F;
      swCode     <= 5'b11100;
      bassCode   <= 4'b0111;
      trebleCode <= 4'b0111;
    end else begin
      if (hitVol)  volCode    <= d[5:0];
      if (hitSw)   swCode     <= d[4:0];
      if (hitBass) bassCode   <= d[3:0];
      if (hitTreb) trebleCode <= d[3:0];
    end
  end

  for (genvar s = 0; s < NUM_SPK; s++) begin : g_spk
    logic [4:0] codeQ;
    always_ff @(posedge clk) begin
      if (!rstN) codeQ <= 5'h1F;
      else if (strobe.valid && d[7] && d[6:5] == 2'(s)) codeQ <= d[4:0];
    end
    assign spkCode[s]     = codeQ;
    assign spkAttenQdb[s] = SPK_QW'(codeQ[4:3]) * SPK_QW'(40) + SPK_QW'(codeQ[2:0]) * SPK_QW'(5);
    assign spkMute[s]     = &codeQ;
  end

  assign volAttenQdb  = VOL_QW'(volCode[5:3]) * VOL_QW'(40) + VOL_QW'(volCode[2:0]) * VOL_QW'(5);
  assign inputSel     = swCode[1:0];
  assign loudnessOn   = ~swCode[2];
  assign gainCode     = swCode[4:3];
  assign inGainQdb    = GAIN_QW'(2'd3 - gainCode) * GAIN_QW'(15);
  assign bassGainDb   = toneDb(bassCode);
  assign trebleGainDb = toneDb(trebleCode);

  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.valid |=> $onehot0({volCode != $past(volCode), swCode != $past(swCode),
                               bassCode != $past(bassCode), trebleCode != $past(trebleCode),
                               spkCode[0] != $past(spkCode[0]), spkCode[1] != $past(spkCode[1]),
                               spkCode[2] != $past(spkCode[2]), spkCode[3] != $past(spkCode[3])}));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.valid |=> $stable({volCode, swCode, bassCode, trebleCode, spkCode}));

  assert_tone_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bassGainDb >= -14 && bassGainDb <= 14 && !bassGainDb[0] &&
     trebleGainDb >= -14 && trebleGainDb <= 14 && !trebleGainDb[0]));
endmodule

// File: rtl/audio_ctrl_i2c_slave.sv
module audio_ctrl_i2c_slave
  import audio_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h44
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           sclIn,
  input  logic                           sdaIn,
  output logic                           sdaOe,
  output logic [5:0]                     volCode,
  output logic [VOL_QW-1:0]              volAttenQdb,
  output logic [NUM_SPK-1:0][4:0]        spkCode,
  output logic [NUM_SPK-1:0][SPK_QW-1:0] spkAttenQdb,
  output logic [NUM_SPK-1:0]             spkMute,
  output logic [1:0]                     inputSel,
  output logic                           loudnessOn,
  output logic [1:0]                     gainCode,
  output logic [GAIN_QW-1:0]             inGainQdb,
  output logic [3:0]                     bassCode,
  output logic [3:0]                     trebleCode,
  output logic signed [TONE_W-1:0]       bassGainDb,
  output logic signed [TONE_W-1:0]       trebleGainDb
);
  byteStrobe_t byteStb;

  i2c_wr_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaOe(sdaOe), .strobe(byteStb)
  );

  audio_reg_bank regs_i (
    .clk(clk), .rstN(rstN), .strobe(byteStb),
    .volCode(volCode), .volAttenQdb(volAttenQdb),
    .spkCode(spkCode), .spkAttenQdb(spkAttenQdb), .spkMute(spkMute),
    .inputSel(inputSel), .loudnessOn(loudnessOn), .gainCode(gainCode),
    .inGainQdb(inGainQdb), .bassCode(bassCode), .trebleCode(trebleCode),
    .bassGainDb(bassGainDb), .trebleGainDb(trebleGainDb)
  );
endmodule

// File: tb/audio_ctrl_i2c_slave_tb_top.sv
module audio_ctrl_i2c_slave_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic [5:0] volCode;
  logic [8:0] volAttenQdb;
  logic [3:0][4:0] spkCode;
  logic [3:0][7:0] spkAttenQdb;
  logic [3:0] spkMute;
  logic [1:0] inputSel, gainCode;
  logic loudnessOn;
  logic [5:0] inGainQdb;
  logic [3:0] bassCode, trebleCode;
  logic signed [4:0] bassGainDb, trebleGainDb;
  int errors = 0;
  int checks = 0;
  logic ackSeen;

  always #10 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  audio_ctrl_i2c_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .volCode(volCode), .volAttenQdb(volAttenQdb), .spkCode(spkCode),
    .spkAttenQdb(spkAttenQdb), .spkMute(spkMute), .inputSel(inputSel),
    .loudnessOn(loudnessOn), .gainCode(gainCode), .inGainQdb(inGainQdb),
    .bassCode(bassCode), .trebleCode(trebleCode),
    .bassGainDb(bassGainDb), .trebleGainDb(trebleGainDb)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(5);
    sclM = 1'b1; tick(10);
    sdaM = 1'b0; tick(10);
    sclM = 1'b0; tick(5);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(5);
    sclM = 1'b1; tick(10);
    sdaM = 1'b1; tick(10);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdaM = b[7-i]; tick(5);
      sclM = 1'b1;   tick(10);
      sclM = 1'b0;   tick(5);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaM = 1'b1; tick(5);
    sclM = 1'b1; tick(5);
    ack = sdaOe;
    tick(5);
    sclM = 1'b0; tick(8);
  endtask

  function automatic int toneExp(input int c);
    return (c >= 8) ? 2 * (7 - (c % 8)) : -14 + 2 * c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    // R11 reset state
    check("R11 volCode", volCode, 63);
    check("R11 volAtten", volAttenQdb, 315);
    check("R11 spkMute", spkMute, 15);
    check("R11 bass", bassCode, 7);
    check("R11 treble", trebleCode, 7);
    check("R11 bassGain", bassGainDb, 0);
    check("R11 inputSel", inputSel, 0);
    check("R11 gainCode", gainCode, 3);
    check("R11 inGain", inGainQdb, 0);
    check("R11 loudness", loudnessOn, 0);
    check("R11 sdaOe", sdaOe, 0);

    // R6 volume sweep in one transfer, R2/R3 ack per byte
    busStart();
    sendByte(8'h88, ackSeen);
    check("R2 address ack", ackSeen, 1);
    for (int c = 0; c < 64; c++) begin
      sendByte(8'(c), ackSeen);
      check("R3 data ack", ackSeen, 1);
      check("R6 volCode", volCode, c);
      check("R6 volAtten", volAttenQdb, 40 * (c / 8) + 5 * (c % 8));
    end
    busStop();
    check("R2 sdaOe idle", sdaOe, 0);

    // R7 speaker sweep
    busStart();
    sendByte(8'h88, ackSeen);
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 32; c++) begin
        sendByte(8'(128 + s * 32 + c), ackSeen);
        check("R7 spkCode", spkCode[s], c);
        check("R7 spkAtten", spkAttenQdb[s], 40 * (c / 8) + 5 * (c % 8));
        check("R7 spkMute", spkMute[s], (c == 31) ? 1 : 0);
        check("R5 volume untouched", volCode, 63);
      end
    end
    // R7 example: right front at 25 dB
    sendByte(8'hB4, ackSeen);
    check("R7 RF example", spkAttenQdb[1], 100);
    check("R5 LF untouched", spkCode[0], 31);
    busStop();

    // R8 switch sweep
    busStart();
    sendByte(8'h88, ackSeen);
    for (int c = 0; c < 32; c++) begin
      sendByte(8'(64 + c), ackSeen);
      check("R8 inputSel", inputSel, c % 4);
      check("R8 loudness", loudnessOn, ((c / 4) % 2 == 0) ? 1 : 0);
      check("R8 gainCode", gainCode, c / 8);
      check("R8 inGain", inGainQdb, 15 * (3 - c / 8));
    end
    // R9 tone sweeps
    for (int c = 0; c < 16; c++) begin
      sendByte(8'(96 + c), ackSeen);
      check("R9 bassCode", bassCode, c);
      check("R9 bassGain", bassGainDb, toneExp(c));
      check("R5 treble untouched", trebleCode, 7);
    end
    for (int c = 0; c < 16; c++) begin
      sendByte(8'(112 + c), ackSeen);
      check("R9 trebleGain", trebleGainDb, toneExp(c));
      check("R5 bass untouched", bassCode, 15);
    end
    sendByte(8'h62, ackSeen);
    check("R9 bass example", bassGainDb, -10);
    sendByte(8'h24, ackSeen);
    check("R6 volume example", volAttenQdb, 180);
    busStop();

    // R4 read bit and wrong address
    busStart();
    sendByte(8'h89, ackSeen);
    check("R4 read form no ack", ackSeen, 0);
    sendByte(8'h00, ackSeen);
    check("R4 skipped byte no ack", ackSeen, 0);
    check("R4 volume unchanged", volCode, 6'h24);
    busStop();
    busStart();
    sendByte(8'h90, ackSeen);
    check("R4 wrong address no ack", ackSeen, 0);
    sendByte(8'h20, ackSeen);
    check("R4 volume unchanged", volCode, 6'h24);
    busStop();

    // R1/R10 repeated START mid-byte
    busStart();
    sendByte(8'h88, ackSeen);
    sendBits(8'h00, 5);
    sclM = 1'b0;
    busStart();
    check("R10 partial byte discarded", volCode, 6'h24);
    sendByte(8'h88, ackSeen);
    check("R1 rematch after repeated start", ackSeen, 1);
    sendByte(8'h2A, ackSeen);
    check("R1 write after restart", volCode, 6'h2A);
    busStop();

    // R10 STOP mid-byte
    busStart();
    sendByte(8'h88, ackSeen);
    sendBits(8'h00, 4);
    busStop();
    tick(10);
    check("R10 aborted by stop", volCode, 6'h2A);
    busStart();
    sendByte(8'h00, ackSeen);
    check("R1 address expected after start", ackSeen, 0);
    busStop();
    check("R1 no write from address slot", volCode, 6'h2A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule